// File: doc/BRIEF.md
# Multistream Byte-Port Buffer Router

This block connects one byte-wide streaming port, driven by an external device, to a bank of internal packet buffers. Each buffer index has a transmit FIFO, which the port fills and the link side drains, and a receive FIFO, which the link side fills and the port drains. The port runs in one of two routing modes. In single-stream mode, which is active after reset, two configuration registers name a fixed transmit buffer and a fixed receive buffer. The read/write line picks between them, and the external buffer address is ignored. In multistream mode, the buffer address presented with each byte picks the buffer on the same clock edge as the data. On receive, the port drives back the index of the buffer that supplied the byte.

Start-of-packet and end-of-packet strobes mark packet boundaries. Once a packet is open, its bytes must all target the same buffer in the same direction. A byte that breaks this rule is discarded and sets a sticky protocol-error flag. A per-buffer stream-type bit (asynchronous or isochronous) is presented alongside outgoing data on both sides. The routing mode can only change while no packet is open.

Top module: `bytestream_router`

## Requirements
- R1: After reset the port is in single-stream mode, `port_rvalid`, `port_addr_oe`, `err_proto` and `err_ovf` are 0, and every FIFO is empty.
- R2: In single-stream mode a byte with `port_rw`=1 is pushed into the transmit FIFO named by configuration register 1 (bits [2:0]), whatever `port_addr_in` holds.
- R3: In single-stream mode a byte with `port_rw`=0 pops the receive FIFO named by configuration register 2 (bits [2:0]), whatever `port_addr_in` holds. `port_addr_oe` stays 0.
- R4: Writing 1 to bit 0 of configuration register 0 selects multistream mode. In that mode a transmit byte goes into the transmit FIFO whose index is on `port_addr_in` at the same clock edge.
- R5: In multistream mode a receive byte pops the receive FIFO whose index is on `port_addr_in`. One cycle later `port_rvalid` is 1 and `port_rdata` holds the head byte. `port_addr_out` carries that index, with `port_addr_oe` 1 while `port_rw` is 0.
- R6: While a packet is open, a byte without `port_sop` whose buffer or direction differs from the packet's is discarded, and `err_proto` becomes 1 and stays 1 until reset.
- R7: A byte with `port_eop` closes the packet, after which any buffer may be used. A byte with `port_sop` inside an open packet starts a new packet on its own buffer without error.
- R8: Each FIFO holds 16 bytes in order. A transmit byte to a full FIFO is dropped, and `err_ovf` becomes 1 and stays 1 until reset.
- R9: A write to configuration register 0 while a packet is open leaves the mode unchanged.
- R10: Bit i of configuration register 3 is the stream type of buffer i (1 = isochronous). It appears on `port_rtype` with each received byte and on `link_tx_type` for the selected transmit buffer.
- R11: A receive byte aimed at an empty receive FIFO yields no `port_rvalid` and does not set `err_proto`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Configuration register index (0 mode, 1 transmit target, 2 receive source, 3 type map) |
| cfg_wdata | input | 8 | Configuration write data |
| port_valid | input | 1 | A byte transfer happens this cycle |
| port_rw | input | 1 | 1 = transmit (device writes), 0 = receive (device reads) |
| port_sop | input | 1 | First byte of a packet |
| port_eop | input | 1 | Last byte of a packet |
| port_addr_in | input | 3 | Buffer index from the device (multistream mode) |
| port_wdata | input | 8 | Transmit byte |
| port_rdata | output | 8 | Received byte |
| port_rvalid | output | 1 | `port_rdata` holds a byte read on the previous edge |
| port_rtype | output | 1 | Stream type of the buffer that supplied `port_rdata` |
| port_addr_out | output | 3 | Index of the supplying buffer, high impedance when not driven |
| port_addr_oe | output | 1 | `port_addr_out` is driven |
| err_proto | output | 1 | Sticky mid-packet buffer-change error |
| err_ovf | output | 1 | Sticky transmit overflow |
| link_tx_sel | input | 3 | Transmit FIFO the link side looks at |
| link_tx_pop | input | 1 | Remove the head of the selected transmit FIFO |
| link_tx_data | output | 8 | Head byte of the selected transmit FIFO |
| link_tx_empty | output | 1 | Selected transmit FIFO is empty |
| link_tx_type | output | 1 | Stream type of the selected transmit buffer |
| link_rx_sel | input | 3 | Receive FIFO the link side fills |
| link_rx_push | input | 1 | Push `link_rx_data` into the selected receive FIFO |
| link_rx_data | input | 8 | Byte for the receive FIFO |
| link_rx_full | output | 1 | Selected receive FIFO is full |

## Verification
A table of multistream transfers interleaves writes to several buffers, reads from two filled buffers and one empty buffer, and single-byte and multi-byte packets. This shows whether the per-byte address really picks the buffer, whether returned indices and types follow the supplying buffer, and whether FIFO order is kept. Single-stream runs put misleading values on the address lines, so a design that wrongly listens to them is caught. Packet runs cover an address change without a start strobe (discard and error), a start strobe inside a packet (legal restart), and a mode write inside and outside a packet. A seventeen-byte burst tells a correct 16-deep FIFO from one that overwrites or drops the wrong byte.

// File: rtl/bsr_pkg.sv
package bsr_pkg;
    localparam int CFG_W = 8;

    typedef enum logic [1:0] {
        REG_MODE  = 2'd0,
        REG_TXTGT = 2'd1,
        REG_RXSRC = 2'd2,
        REG_TYPE  = 2'd3
    } reg_sel_e;

    typedef enum logic {
        STREAM_ASYNC = 1'b0,
        STREAM_ISO   = 1'b1
    } stream_type_e;
endpackage

// File: rtl/bsr_fifo.sv
module bsr_fifo #(
    parameter int DEPTH = 16,
    parameter int W     = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] wdata,
    input  logic         pop,
    output logic [W-1:0] rdata,
    output logic         full,
    output logic         empty
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = PTR_W + 1;
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [PTR_W-1:0]        wp;
        logic [PTR_W-1:0]        rp;
        logic [CNT_W-1:0]        cnt;
    } fifo_t;

    fifo_t f_d, f_q;
    logic  do_push, do_pop;

    assign full    = (f_q.cnt == FULL_CNT);
    assign empty   = (f_q.cnt == '0);
    assign rdata   = f_q.mem[f_q.rp];
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;

    always_comb begin
        f_d = f_q;
        if (do_push) begin
            f_d.mem[f_q.wp] = wdata;
            f_d.wp = (f_q.wp == LAST) ? '0 : f_q.wp + 1'b1;
        end
        if (do_pop) begin
            f_d.rp = (f_q.rp == LAST) ? '0 : f_q.rp + 1'b1;
        end
        case ({do_push, do_pop})
            2'b10:   f_d.cnt = f_q.cnt + 1'b1;
            2'b01:   f_d.cnt = f_q.cnt - 1'b1;
            default: f_d.cnt = f_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end
endmodule

// File: rtl/bsr_cfg.sv
module bsr_cfg
    import bsr_pkg::*;
#(
    parameter int NUM_BUF = 8,
    parameter int SEL_W   = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we,
    input  logic [1:0]         waddr,
    input  logic [CFG_W-1:0]   wdata,
    input  logic               pkt_busy,
    output logic               ms_mode,
    output logic [SEL_W-1:0]   tx_tgt,
    output logic [SEL_W-1:0]   rx_src,
    output logic [NUM_BUF-1:0] type_map
);
    typedef struct packed {
        logic               ms;
        logic [SEL_W-1:0]   tx;
        logic [SEL_W-1:0]   rx;
        logic [NUM_BUF-1:0] types;
    } cfg_t;

    cfg_t c_d, c_q;

    always_comb begin
        c_d = c_q;
        if (we) begin
            case (reg_sel_e'(waddr))
                REG_MODE:  if (!pkt_busy) c_d.ms = wdata[0];
                REG_TXTGT: c_d.tx = wdata[SEL_W-1:0];
                REG_RXSRC: c_d.rx = wdata[SEL_W-1:0];
                REG_TYPE:  c_d.types = wdata[NUM_BUF-1:0];
                default:   c_d = c_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign ms_mode  = c_q.ms;
    assign tx_tgt   = c_q.tx;
    assign rx_src   = c_q.rx;
    assign type_map = c_q.types;
endmodule

// File: rtl/bsr_pkt_guard.sv
module bsr_pkt_guard #(
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             valid,
    input  logic             rw,
    input  logic             sop,
    input  logic             eop,
    input  logic [SEL_W-1:0] addr_in,
    input  logic             ms_mode,
    input  logic [SEL_W-1:0] tx_tgt,
    input  logic [SEL_W-1:0] rx_src,
    output logic [SEL_W-1:0] sel,
    output logic             accept,
    output logic             busy,
    output logic             err
);
    typedef struct packed {
        logic             busy;
        logic             dir;
        logic [SEL_W-1:0] bufsel;
        logic             err;
    } guard_t;

    guard_t g_d, g_q;
    logic   mismatch;

    assign sel      = ms_mode ? addr_in : (rw ? tx_tgt : rx_src);
    assign mismatch = g_q.busy && !sop && ((sel != g_q.bufsel) || (rw != g_q.dir));
    assign accept   = valid && !mismatch;

    always_comb begin
        g_d = g_q;
        if (valid && mismatch) g_d.err = 1'b1;
        if (accept) begin
            if (sop) begin
                g_d.busy   = 1'b1;
                g_d.bufsel = sel;
                g_d.dir    = rw;
            end
            if (eop) g_d.busy = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) g_q <= '0;
        else        g_q <= g_d;
    end

    assign busy = g_q.busy;
    assign err  = g_q.err;
endmodule

// File: rtl/bytestream_router.sv
module bytestream_router
    import bsr_pkg::*;
#(
    parameter int NUM_BUF   = 8,
    parameter int BUF_DEPTH = 16,
    parameter int DATA_W    = 8,
    localparam int SEL_W    = $clog2(NUM_BUF)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_addr,
    input  logic [CFG_W-1:0]  cfg_wdata,
    input  logic              port_valid,
    input  logic              port_rw,
    input  logic              port_sop,
    input  logic              port_eop,
    input  logic [SEL_W-1:0]  port_addr_in,
    input  logic [DATA_W-1:0] port_wdata,
    output logic [DATA_W-1:0] port_rdata,
    output logic              port_rvalid,
    output logic              port_rtype,
    output wire  [SEL_W-1:0]  port_addr_out,
    output logic              port_addr_oe,
    output logic              err_proto,
    output logic              err_ovf,
    input  logic [SEL_W-1:0]  link_tx_sel,
    input  logic              link_tx_pop,
    output logic [DATA_W-1:0] link_tx_data,
    output logic              link_tx_empty,
    output logic              link_tx_type,
    input  logic [SEL_W-1:0]  link_rx_sel,
    input  logic              link_rx_push,
    input  logic [DATA_W-1:0] link_rx_data,
    output logic              link_rx_full
);
    logic               ms_mode, pkt_busy, accept;
    logic [SEL_W-1:0]   tx_tgt, rx_src, route_sel;
    logic [NUM_BUF-1:0] type_map;
    logic [NUM_BUF-1:0] tx_full, tx_empty, rx_full, rx_empty;
    logic [NUM_BUF-1:0] tx_push, rx_pop;
    logic [DATA_W-1:0]  tx_head [NUM_BUF];
    logic [DATA_W-1:0]  rx_head [NUM_BUF];

    bsr_cfg #(.NUM_BUF(NUM_BUF), .SEL_W(SEL_W)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (cfg_we),
        .waddr    (cfg_addr),
        .wdata    (cfg_wdata),
        .pkt_busy (pkt_busy),
        .ms_mode  (ms_mode),
        .tx_tgt   (tx_tgt),
        .rx_src   (rx_src),
        .type_map (type_map)
    );

    bsr_pkt_guard #(.SEL_W(SEL_W)) u_guard (
        .clk     (clk),
        .rst_n   (rst_n),
        .valid   (port_valid),
        .rw      (port_rw),
        .sop     (port_sop),
        .eop     (port_eop),
        .addr_in (port_addr_in),
        .ms_mode (ms_mode),
        .tx_tgt  (tx_tgt),
        .rx_src  (rx_src),
        .sel     (route_sel),
        .accept  (accept),
        .busy    (pkt_busy),
        .err     (err_proto)
    );

    for (genvar i = 0; i < NUM_BUF; i++) begin : g_buf
        assign tx_push[i] = accept && port_rw && (route_sel == SEL_W'(i));
        assign rx_pop[i]  = accept && !port_rw && (route_sel == SEL_W'(i));

        bsr_fifo #(.DEPTH(BUF_DEPTH), .W(DATA_W)) u_tx (
            .clk   (clk),
            .rst_n (rst_n),
            .push  (tx_push[i]),
            .wdata (port_wdata),
            .pop   (link_tx_pop && (link_tx_sel == SEL_W'(i))),
            .rdata (tx_head[i]),
            .full  (tx_full[i]),
            .empty (tx_empty[i])
        );

        bsr_fifo #(.DEPTH(BUF_DEPTH), .W(DATA_W)) u_rx (
            .clk   (clk),
            .rst_n (rst_n),
            .push  (link_rx_push && (link_rx_sel == SEL_W'(i))),
            .wdata (link_rx_data),
            .pop   (rx_pop[i]),
            .rdata (rx_head[i]),
            .full  (rx_full[i]),
            .empty (rx_empty[i])
        );
    end

    typedef struct packed {
        logic              rvalid;
        logic [DATA_W-1:0] rdata;
        logic [SEL_W-1:0]  rbuf;
        logic              rtype;
        logic              ovf;
    } out_t;

    out_t o_d, o_q;

    always_comb begin
        o_d = o_q;
        o_d.rvalid = accept && !port_rw && !rx_empty[route_sel];
        if (o_d.rvalid) begin
            o_d.rdata = rx_head[route_sel];
            o_d.rbuf  = route_sel;
            o_d.rtype = type_map[route_sel];
        end
        if (accept && port_rw && tx_full[route_sel]) o_d.ovf = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) o_q <= '0;
        else        o_q <= o_d;
    end

    assign port_rvalid   = o_q.rvalid;
    assign port_rdata    = o_q.rdata;
    assign port_rtype    = o_q.rtype;
    assign err_ovf       = o_q.ovf;
    assign port_addr_oe  = ms_mode && !port_rw;
    assign port_addr_out = port_addr_oe ? o_q.rbuf : 'z;

    assign link_tx_data  = tx_head[link_tx_sel];
    assign link_tx_empty = tx_empty[link_tx_sel];
    assign link_tx_type  = type_map[link_tx_sel];
    assign link_rx_full  = rx_full[link_rx_sel];
endmodule

// File: rtl/bsr_checker.sv
module bsr_checker #(
    parameter int NUM_BUF = 8,
    parameter int SEL_W   = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic               port_valid,
    input logic               port_rw,
    input logic               port_rvalid,
    input logic               err_proto,
    input logic               err_ovf,
    input logic               pkt_busy,
    input logic               ms_mode,
    input logic [NUM_BUF-1:0] rx_empty,
    input logic [SEL_W-1:0]   route_sel
);
    a_r6_proto_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err_proto |=> err_proto);

    a_r8_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err_ovf |=> err_ovf);

    a_r5_rvalid_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        port_rvalid |-> $past(port_valid && !port_rw));

    a_r11_empty_read_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (port_valid && !port_rw && rx_empty[route_sel]) |=> !port_rvalid);

    a_r9_mode_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_busy |=> $stable(ms_mode));
endmodule

bind bytestream_router bsr_checker #(.NUM_BUF(NUM_BUF), .SEL_W(SEL_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .port_valid  (port_valid),
    .port_rw     (port_rw),
    .port_rvalid (port_rvalid),
    .err_proto   (err_proto),
    .err_ovf     (err_ovf),
    .pkt_busy    (pkt_busy),
    .ms_mode     (ms_mode),
    .rx_empty    (rx_empty),
    .route_sel   (route_sel)
);

// File: tb/tb_bytestream_router.sv
module tb_bytestream_router;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [1:0] cfg_addr = '0;
    logic [7:0] cfg_wdata = '0;
    logic       port_valid = 1'b0, port_rw = 1'b0, port_sop = 1'b0, port_eop = 1'b0;
    logic [2:0] port_addr_in = '0;
    logic [7:0] port_wdata = '0;
    logic [7:0] port_rdata;
    logic       port_rvalid, port_rtype, port_addr_oe, err_proto, err_ovf;
    wire  [2:0] port_addr_out;
    logic [2:0] link_tx_sel = '0;
    logic       link_tx_pop = 1'b0;
    logic [7:0] link_tx_data;
    logic       link_tx_empty, link_tx_type;
    logic [2:0] link_rx_sel = '0;
    logic       link_rx_push = 1'b0;
    logic [7:0] link_rx_data = '0;
    logic       link_rx_full;

    int nchk = 0;
    int nfail = 0;
    bit done = 1'b0;

    always #2.5ns clk = ~clk;

    bytestream_router dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .port_valid(port_valid), .port_rw(port_rw), .port_sop(port_sop), .port_eop(port_eop),
        .port_addr_in(port_addr_in), .port_wdata(port_wdata), .port_rdata(port_rdata),
        .port_rvalid(port_rvalid), .port_rtype(port_rtype), .port_addr_out(port_addr_out),
        .port_addr_oe(port_addr_oe), .err_proto(err_proto), .err_ovf(err_ovf),
        .link_tx_sel(link_tx_sel), .link_tx_pop(link_tx_pop), .link_tx_data(link_tx_data),
        .link_tx_empty(link_tx_empty), .link_tx_type(link_tx_type), .link_rx_sel(link_rx_sel),
        .link_rx_push(link_rx_push), .link_rx_data(link_rx_data), .link_rx_full(link_rx_full)
    );

    typedef struct packed {
        logic       rw;
        logic       sop;
        logic       eop;
        logic [2:0] a;
        logic [7:0] d;
        logic       ev;
        logic [7:0] ed;
        logic       et;
    } vec_t;

    // multistream table; buffer 2 is isochronous; rx 1 = 11,12 and rx 2 = 21 preloaded
    localparam vec_t VEC [8] = '{
        '{1'b1, 1'b1, 1'b0, 3'd3, 8'hA0, 1'b0, 8'h00, 1'b0},
        '{1'b1, 1'b0, 1'b1, 3'd3, 8'hA1, 1'b0, 8'h00, 1'b0},
        '{1'b1, 1'b1, 1'b1, 3'd5, 8'hB0, 1'b0, 8'h00, 1'b0},
        '{1'b0, 1'b1, 1'b0, 3'd1, 8'h00, 1'b1, 8'h11, 1'b0},
        '{1'b0, 1'b0, 1'b1, 3'd1, 8'h00, 1'b1, 8'h12, 1'b0},
        '{1'b0, 1'b1, 1'b1, 3'd2, 8'h00, 1'b1, 8'h21, 1'b1},
        '{1'b0, 1'b1, 1'b1, 3'd4, 8'h00, 1'b0, 8'h00, 1'b0},
        '{1'b1, 1'b1, 1'b1, 3'd2, 8'hC7, 1'b0, 8'h00, 1'b0}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic cfg_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic xfer(input logic rw, input logic sop, input logic eop,
                        input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        port_valid = 1'b1; port_rw = rw; port_sop = sop; port_eop = eop;
        port_addr_in = a; port_wdata = d;
        @(negedge clk);
        port_valid = 1'b0; port_rw = 1'b0; port_sop = 1'b0; port_eop = 1'b0;
    endtask

    task automatic link_push(input logic [2:0] b, input logic [7:0] d);
        @(negedge clk);
        link_rx_sel = b; link_rx_data = d; link_rx_push = 1'b1;
        @(negedge clk);
        link_rx_push = 1'b0;
    endtask

    task automatic link_pop_check(input string req, input logic [2:0] b, input logic [7:0] exp);
        @(negedge clk);
        link_tx_sel = b;
        #1ns;
        check(req, {31'd0, link_tx_empty}, 32'd0);
        check(req, {24'd0, link_tx_data}, {24'd0, exp});
        link_tx_pop = 1'b1;
        @(negedge clk);
        link_tx_pop = 1'b0;
    endtask

    task automatic link_empty_check(input string req, input logic [2:0] b);
        @(negedge clk);
        link_tx_sel = b;
        #1ns;
        check(req, {31'd0, link_tx_empty}, 32'd1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL R1 watchdog: act=running exp=finished");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        do_reset();
        check("R1 rvalid", {31'd0, port_rvalid}, 32'd0);
        check("R1 oe", {31'd0, port_addr_oe}, 32'd0);
        check("R1 err_proto", {31'd0, err_proto}, 32'd0);
        check("R1 err_ovf", {31'd0, err_ovf}, 32'd0);
        link_empty_check("R1 tx empty", 3'd0);

        // table walk: R4, R5, R10, R11
        cfg_write(2'd0, 8'h01);
        cfg_write(2'd3, 8'h04);
        link_push(3'd1, 8'h11);
        link_push(3'd1, 8'h12);
        link_push(3'd2, 8'h21);
        foreach (VEC[i]) begin
            xfer(VEC[i].rw, VEC[i].sop, VEC[i].eop, VEC[i].a, VEC[i].d);
            check("R5/R11 rvalid", {31'd0, port_rvalid}, {31'd0, VEC[i].ev});
            if (VEC[i].ev) begin
                check("R5 rdata", {24'd0, port_rdata}, {24'd0, VEC[i].ed});
                check("R5 addr_oe", {31'd0, port_addr_oe}, 32'd1);
                check("R5 addr_out", {29'd0, port_addr_out}, {29'd0, VEC[i].a});
                check("R10 rtype", {31'd0, port_rtype}, {31'd0, VEC[i].et});
            end
        end
        check("R11 no err", {31'd0, err_proto}, 32'd0);
        link_pop_check("R4 buf3", 3'd3, 8'hA0);
        link_pop_check("R4 buf3", 3'd3, 8'hA1);
        link_pop_check("R4 buf5", 3'd5, 8'hB0);
        link_tx_sel = 3'd2; #1ns;
        check("R10 link type", {31'd0, link_tx_type}, 32'd1);
        link_pop_check("R4 buf2", 3'd2, 8'hC7);
        link_empty_check("R4 buf0 untouched", 3'd0);

        // R2, R3 single-stream with misleading addresses
        do_reset();
        cfg_write(2'd1, 8'h06);
        cfg_write(2'd2, 8'h02);
        link_push(3'd2, 8'h5A);
        xfer(1'b1, 1'b1, 1'b1, 3'd1, 8'hC3);
        link_empty_check("R2 addr ignored", 3'd1);
        link_pop_check("R2 tx target", 3'd6, 8'hC3);
        xfer(1'b0, 1'b1, 1'b1, 3'd7, 8'h00);
        check("R3 rvalid", {31'd0, port_rvalid}, 32'd1);
        check("R3 rdata", {24'd0, port_rdata}, 32'h5A);
        check("R3 oe low", {31'd0, port_addr_oe}, 32'd0);

        // R6 mid-packet buffer change
        do_reset();
        cfg_write(2'd0, 8'h01);
        xfer(1'b1, 1'b1, 1'b0, 3'd0, 8'h01);
        xfer(1'b1, 1'b0, 1'b0, 3'd4, 8'h02);
        check("R6 err set", {31'd0, err_proto}, 32'd1);
        xfer(1'b1, 1'b0, 1'b1, 3'd0, 8'h03);
        link_empty_check("R6 discarded", 3'd4);
        link_pop_check("R6 buf0", 3'd0, 8'h01);
        link_pop_check("R6 buf0", 3'd0, 8'h03);
        xfer(1'b1, 1'b1, 1'b1, 3'd1, 8'h09);
        check("R6 sticky", {31'd0, err_proto}, 32'd1);

        // R7 restart and close
        do_reset();
        cfg_write(2'd0, 8'h01);
        xfer(1'b1, 1'b1, 1'b0, 3'd2, 8'hD1);
        xfer(1'b1, 1'b1, 1'b0, 3'd5, 8'hD2);
        xfer(1'b1, 1'b0, 1'b1, 3'd5, 8'hD3);
        xfer(1'b1, 1'b1, 1'b1, 3'd6, 8'hD4);
        check("R7 no err", {31'd0, err_proto}, 32'd0);
        link_pop_check("R7 buf2", 3'd2, 8'hD1);
        link_pop_check("R7 buf5", 3'd5, 8'hD2);
        link_pop_check("R7 buf5", 3'd5, 8'hD3);
        link_pop_check("R7 buf6", 3'd6, 8'hD4);

        // R9 mode write during packet
        do_reset();
        xfer(1'b1, 1'b1, 1'b0, 3'd0, 8'h44);
        cfg_write(2'd0, 8'h01);
        check("R9 mode held", {31'd0, port_addr_oe}, 32'd0);
        xfer(1'b1, 1'b0, 1'b1, 3'd0, 8'h45);
        cfg_write(2'd0, 8'h01);
        check("R9 mode taken", {31'd0, port_addr_oe}, 32'd1);

        // R8 overflow
        do_reset();
        for (int k = 0; k < 16; k++) xfer(1'b1, 1'b0, 1'b0, 3'd0, 8'(k));
        check("R8 no ovf at 16", {31'd0, err_ovf}, 32'd0);
        xfer(1'b1, 1'b0, 1'b0, 3'd0, 8'hEE);
        check("R8 ovf", {31'd0, err_ovf}, 32'd1);
        for (int k = 0; k < 16; k++) link_pop_check("R8 order", 3'd0, 8'(k));
        link_empty_check("R8 dropped", 3'd0);
        check("R8 sticky", {31'd0, err_ovf}, 32'd1);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule